// File: doc/BRIEF.md
# Two-Mode Prioritized Interrupt Controller

The controller gathers a set of maskable interrupt lines, plus one non-maskable line and one address-break line. From these it presents the CPU with a single registered request: a valid strobe and a vector index. Each maskable source has an enable bit, a one-bit priority entry and a trigger-type bit. A trigger-type bit of 1 makes the source edge-latched. A trigger-type bit of 0 makes it follow the line level. The non-maskable and address-break lines are always edge-latched.

A two-bit mode field picks the masking scheme. The single-mask mode uses the CPU's primary mask bit and nothing else. The tiered mode combines the primary and secondary mask bits into three levels. These levels admit everything, only high-priority sources, or no maskable source at all. Once a vector is presented it stays frozen until the CPU pulses acknowledge. The acknowledge also clears the latched request behind that vector.

A standby input holds off all acceptance. It also discards every edge-latched request, as asynchronous reset does.

Top module: `irq_tier_ctl`

## Requirements
- R1: While rst_ni is low or standby_i is high, irq_valid_o is 0. Asserting standby_i drops irq_valid_o at the next clock edge. Standby also discards latched edges, so a non-maskable edge seen during standby is never delivered.
- R2: A rising edge on nmi_i or brk_i is delivered no matter what the enables, priorities, mode and mask bits are set to.
- R3: A maskable source whose src_en_i bit is 0 is never delivered.
- R4: In mode 00, mask_i_i=1 blocks every maskable source, and mask_i_i=0 admits every enabled source. mask_ui_i has no effect in this mode.
- R5: In mode 01, three levels apply. mask_i_i=0 admits all enabled sources. mask_i_i=1 with mask_ui_i=0 admits only sources whose src_prio_i bit is 1. mask_i_i=1 with mask_ui_i=1 blocks every maskable source.
- R6: Mode values 10 and 11 behave exactly like mode 00.
- R7: When several requests compete, the winner is chosen in this order: non-maskable, then address break, then admitted sources with priority bit 1, then admitted sources with priority bit 0. Within a class, the lowest source index wins.
- R8: Vector encoding: 0 is non-maskable, 1 is address break, and 2+k is maskable source k.
- R9: irq_valid_o and irq_vec_o are registered. Once valid, they hold unchanged until ack_i is sampled high. The cycle after that, valid is 0. ack_i sampled while valid is 0 has no effect.
- R10: An edge-type source (src_edge_i bit 1) latches a rising edge, and acknowledging its vector clears the latch. A level-type source (bit 0) is requested only while its line is high. If the line is still high after acknowledge, the source is presented again. A level request is registered one clock edge after it is sampled. An edge request is registered two clock edges after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| standby_i | input | 1 | Blocks acceptance and discards latched edges |
| nmi_i | input | 1 | Non-maskable request line, rising-edge sensitive |
| brk_i | input | 1 | Address-break request line, rising-edge sensitive |
| src_req_i | input | N_SRC | Maskable request lines |
| src_edge_i | input | N_SRC | Per-source trigger type: 1 edge, 0 level |
| src_en_i | input | N_SRC | Per-source enable |
| src_prio_i | input | N_SRC | Per-source priority: 1 high, 0 low |
| mode_i | input | 2 | Mode field: 01 tiered, others single-mask |
| mask_i_i | input | 1 | CPU primary mask bit |
| mask_ui_i | input | 1 | CPU secondary mask bit |
| ack_i | input | 1 | CPU acknowledge of the presented vector |
| irq_valid_o | output | 1 | Registered request strobe |
| irq_vec_o | output | VEC_W | Registered vector index |

## Verification
A wrong mask gate or priority scan shows up within one clock edge of a level request. irq_irq_vec_o then names a source that should have lost, or irq_valid_o rises when it should stay low. A stuck or uncleared edge latch shows up two edges after the acknowledge, as a repeated delivery of the same vector. A broken hold register shows up as a vector that changes while irq_valid_o is high and ack_i is low. The bench sweeps every mode value against every mask-bit pair, across many request, enable and priority patterns.

// File: rtl/irq_tier_pkg.sv
package irq_tier_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_TIER   = 2'b01,
    MODE_RSV_A  = 2'b10,
    MODE_RSV_B  = 2'b11
  } irq_mode_e;

  localparam int unsigned VEC_NMI  = 0;
  localparam int unsigned VEC_BRK  = 1;
  localparam int unsigned VEC_BASE = 2;

  function automatic logic is_tier(input logic [1:0] mode);
    return mode == MODE_TIER;
  endfunction
endpackage

// File: rtl/irq_pend_cell.sv
module irq_pend_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  logic line_i,
  input  logic edge_mode_i,
  input  logic clr_i,
  output logic pend_o
);
  logic line_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      line_q <= line_i;
      if (flush_i) pend_q <= 1'b0;
      else         pend_q <= (pend_q & ~clr_i) | (line_i & ~line_q); // new edge beats clear
    end
  end

  assign pend_o = edge_mode_i ? pend_q : line_i;
endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import irq_tier_pkg::*;
#(
  parameter int unsigned N_SRC = 8,
  parameter int unsigned VEC_W = $clog2(N_SRC + VEC_BASE)
) (
  input  logic             nmi_pend_i,
  input  logic             brk_pend_i,
  input  logic [N_SRC-1:0] src_pend_i,
  input  logic [N_SRC-1:0] src_en_i,
  input  logic [N_SRC-1:0] src_prio_i,
  input  logic [1:0]       mode_i,
  input  logic             mask_i_i,
  input  logic             mask_ui_i,
  output logic             win_valid_o,
  output logic [VEC_W-1:0] win_vec_o
);
  logic [N_SRC-1:0] gate, admit, hi, lo;
  logic             hi_any, lo_any;
  logic [VEC_W-1:0] hi_vec, lo_vec;

  for (genvar k = 0; k < N_SRC; k++) begin : g_gate
    assign gate[k] = is_tier(mode_i) ? (~mask_i_i | (~mask_ui_i & src_prio_i[k])) : ~mask_i_i;
  end

  assign admit = src_pend_i & src_en_i & gate;
  assign hi    = admit & src_prio_i;
  assign lo    = admit & ~src_prio_i;

  // scan downward so the lowest index ends up selected
  always_comb begin
    hi_any = 1'b0;
    lo_any = 1'b0;
    hi_vec = '0;
    lo_vec = '0;
    for (int k = N_SRC - 1; k >= 0; k--) begin
      if (hi[k]) begin
        hi_any = 1'b1;
        hi_vec = VEC_W'(VEC_BASE + k);
      end
      if (lo[k]) begin
        lo_any = 1'b1;
        lo_vec = VEC_W'(VEC_BASE + k);
      end
    end
  end

  always_comb begin
    win_valid_o = 1'b1;
    if (nmi_pend_i)      win_vec_o = VEC_W'(VEC_NMI);
    else if (brk_pend_i) win_vec_o = VEC_W'(VEC_BRK);
    else if (hi_any)     win_vec_o = hi_vec;
    else if (lo_any)     win_vec_o = lo_vec;
    else begin
      win_valid_o = 1'b0;
      win_vec_o   = '0;
    end
  end
endmodule

// File: rtl/irq_tier_ctl.sv
module irq_tier_ctl
  import irq_tier_pkg::*;
#(
  parameter int unsigned N_SRC = 8,
  localparam int unsigned VEC_W = $clog2(N_SRC + VEC_BASE),
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             standby_i,
  input  logic             nmi_i,
  input  logic             brk_i,
  input  logic [N_SRC-1:0] src_req_i,
  input  logic [N_SRC-1:0] src_edge_i,
  input  logic [N_SRC-1:0] src_en_i,
  input  logic [N_SRC-1:0] src_prio_i,
  input  logic [1:0]       mode_i,
  input  logic             mask_i_i,
  input  logic             mask_ui_i,
  input  logic             ack_i,
  output logic             irq_valid_o,
  output logic [VEC_W-1:0] irq_vec_o
);
  logic             valid_q;
  logic [VEC_W-1:0] vec_q;
  logic             ack_take;
  logic             nmi_pend, brk_pend;
  logic [N_SRC-1:0] src_pend;
  logic             win_valid;
  logic [VEC_W-1:0] win_vec;

  assign ack_take = ack_i & valid_q;

  irq_pend_cell u_nmi (
    .clk_i, .rst_ni, .flush_i(standby_i), .line_i(nmi_i), .edge_mode_i(1'b1),
    .clr_i(ack_take && vec_q == VEC_W'(VEC_NMI)), .pend_o(nmi_pend)
  );

  irq_pend_cell u_brk (
    .clk_i, .rst_ni, .flush_i(standby_i), .line_i(brk_i), .edge_mode_i(1'b1),
    .clr_i(ack_take && vec_q == VEC_W'(VEC_BRK)), .pend_o(brk_pend)
  );

  for (genvar k = 0; k < N_SRC; k++) begin : g_src
    irq_pend_cell u_cell (
      .clk_i, .rst_ni, .flush_i(standby_i), .line_i(src_req_i[k]),
      .edge_mode_i(src_edge_i[k]),
      .clr_i(ack_take && vec_q == VEC_W'(VEC_BASE + k)), .pend_o(src_pend[k])
    );
  end

  irq_arb #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_arb (
    .nmi_pend_i(nmi_pend), .brk_pend_i(brk_pend), .src_pend_i(src_pend),
    .src_en_i, .src_prio_i, .mode_i, .mask_i_i, .mask_ui_i,
    .win_valid_o(win_valid), .win_vec_o(win_vec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      vec_q   <= '0;
    end else if (standby_i) begin
      valid_q <= 1'b0;
    end else if (valid_q) begin
      if (ack_i) valid_q <= 1'b0;
    end else if (win_valid) begin
      valid_q <= 1'b1;
      vec_q   <= win_vec;
    end
  end

  assign irq_valid_o = valid_q;
  assign irq_vec_o   = vec_q;

  // R9
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && !ack_i && !standby_i |=> valid_q && $stable(vec_q));
  // R9
  ack_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && ack_i |=> !valid_q);
  // R1
  standby_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |=> !valid_q);
  // R3
  en_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid && win_vec >= VEC_W'(VEC_BASE) |-> src_en_i[IDX_W'(win_vec - VEC_W'(VEC_BASE))]);
  // R4
  single_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid && mode_i != 2'b01 && mask_i_i |-> win_vec < VEC_W'(VEC_BASE));
  // R5
  tier_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid && mode_i == 2'b01 && mask_i_i && mask_ui_i |-> win_vec < VEC_W'(VEC_BASE));
  // R7
  nmi_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_pend && !standby_i && !valid_q |=> valid_q && vec_q == VEC_W'(VEC_NMI));
endmodule

// File: tb/irq_tier_ctl_tb_top.sv
module irq_tier_ctl_tb_top;
  localparam int N = 8;
  localparam int VW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic standby = 1'b0, nmi = 1'b0, brk = 1'b0, ack = 1'b0;
  logic [N-1:0] req = '0, edg = '0, en = '0, prio = '0;
  logic [1:0] mode = 2'b00;
  logic mi = 1'b0, mui = 1'b0;
  logic valid;
  logic [VW-1:0] vec;

  int n_chk = 0, n_bad = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #10 clk = ~clk;

  irq_tier_ctl #(.N_SRC(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .standby_i(standby), .nmi_i(nmi), .brk_i(brk),
    .src_req_i(req), .src_edge_i(edg), .src_en_i(en), .src_prio_i(prio),
    .mode_i(mode), .mask_i_i(mi), .mask_ui_i(mui), .ack_i(ack),
    .irq_valid_o(valid), .irq_vec_o(vec)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic logic [4:0] model(input logic n_, input logic b_, input logic [N-1:0] rq,
      input logic [N-1:0] e_, input logic [N-1:0] p_, input logic [1:0] m_, input logic i_, input logic u_);
    logic [N-1:0] adm;
    for (int k = 0; k < N; k++)
      adm[k] = rq[k] & e_[k] & ((m_ == 2'b01) ? (!i_ || (!u_ && p_[k])) : !i_);
    if (n_) return 5'h10;
    if (b_) return 5'h11;
    for (int k = 0; k < N; k++) if (adm[k] && p_[k])  return {1'b1, 4'(k + 2)};
    for (int k = 0; k < N; k++) if (adm[k] && !p_[k]) return {1'b1, 4'(k + 2)};
    return 5'h00;
  endfunction

  function automatic string tag(input logic n_, input logic b_, input logic [1:0] m_, input logic i_, input logic u_);
    if (n_ || b_)                    return "R2/R7/R8";
    if (m_ >= 2'b10)                 return "R6/R3/R7";
    if (m_ == 2'b01 && i_ && u_)     return "R5_block";
    if (m_ == 2'b01)                 return "R5/R3/R7";
    return "R4/R3/R7";
  endfunction

  task automatic drain();
    @(negedge clk);
    req = '0; nmi = 1'b0; brk = 1'b0;
    repeat (4) begin
      ack = valid;
      @(negedge clk);
    end
    ack = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [4:0] exp;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", 32'(valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 post-reset valid", 32'(valid), 0);

    // sweep: every mode x mask pair x pseudo-random level patterns
    for (int m = 0; m < 4; m++) begin
      for (int mk = 0; mk < 4; mk++) begin
        for (int p = 0; p < 48; p++) begin
          lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
          lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
          lfsr = lfsr * 32'd1103515245 + 32'd12345;
          mode = 2'(m); mi = mk[1]; mui = mk[0];
          en = lfsr[15:8]; prio = lfsr[23:16]; edg = '0;
          nmi = lfsr[24] & lfsr[25] & lfsr[26];
          brk = lfsr[27] & lfsr[28];
          @(negedge clk);
          req = lfsr[7:0];
          @(negedge clk);
          exp = model(nmi, brk, req, en, prio, mode, mi, mui);
          chk(tag(nmi, brk, mode, mi, mui), {27'd0, valid, vec & {VW{valid}}}, {27'd0, exp});
          drain();
          chk("R9 drained", 32'(valid), 0);
        end
      end
    end

    // R10 edge-type source: latched, cleared by ack
    mode = 2'b00; mi = 1'b0; mui = 1'b0; en = '1; prio = '0; edg = 8'h08;
    @(negedge clk); req[3] = 1'b1;
    @(negedge clk); req[3] = 1'b0;
    @(negedge clk);
    chk("R10 edge latched", {31'd0, valid}, 1);
    chk("R10 edge vec", 32'(vec), 5);
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 edge cleared", 32'(valid), 0);

    // R10 level source re-presents while high; R9 hold while line drops
    edg = '0; req[2] = 1'b1;
    @(negedge clk);
    chk("R10 level latency", {31'd0, valid}, 1);
    chk("R10 level vec", 32'(vec), 4);
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    chk("R9 ack drops valid", 32'(valid), 0);
    @(negedge clk);
    chk("R10 level re-presented", {27'd0, valid, vec}, {27'd0, 5'h14});
    req[2] = 1'b0; mi = 1'b1; req[0] = 1'b1; nmi = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 held vec", {27'd0, valid, vec}, {27'd0, 5'h14});
    ack = 1'b1; @(negedge clk); ack = 1'b0; @(negedge clk);
    chk("R7 nmi after hold", {27'd0, valid, vec}, {27'd0, 5'h10});
    drain();
    mi = 1'b0;

    // R9 ack while idle ignored
    ack = 1'b1; repeat (2) @(negedge clk); ack = 1'b0;
    chk("R9 idle ack valid", 32'(valid), 0);
    req[6] = 1'b1; @(negedge clk);
    chk("R9 after idle ack", {27'd0, valid, vec}, {27'd0, 5'h18});
    drain();

    // R1 standby discards nmi edge and drops valid
    standby = 1'b1; nmi = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 standby blocks nmi", 32'(valid), 0);
    standby = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 nmi edge discarded", 32'(valid), 0);
    nmi = 1'b0;
    req[1] = 1'b1; @(negedge clk);
    chk("R1 pre-standby valid", {27'd0, valid, vec}, {27'd0, 5'h13});
    standby = 1'b1; @(negedge clk);
    chk("R1 standby drops valid", 32'(valid), 0);
    standby = 1'b0;
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule